// File: doc/BRIEF.md
# Phase-Corrected Trigger Delay Generator

This block issues an output pulse a programmed number of clock cycles after an asynchronous trigger, and cancels the trigger's random phase relative to the clock. On the clock edge that first detects a trigger, the block samples a thermometer code from an external tapped delay line. That code gives how far into the clock period the trigger arrived. The block counts whole cycles, then drives a registered coarse pulse. It also presents a tap-select code, so that an external output delay line adds the complementary fraction of a period. The input fraction and the output fraction always sum to exactly one clock period. Because of this, the corrected output edge keeps a fixed distance from the trigger, whatever the trigger's phase.

The control path is a three-state machine. ST_IDLE waits for an armed trigger. The transition IDLE→COUNT happens on capture. ST_COUNT counts the requested cycles, and the transition COUNT→PULSE happens when the count runs out. ST_PULSE holds the coarse pulse for the programmed length, and the transition PULSE→IDLE happens when that length ends. The tap select is loaded at capture. It then holds for the whole busy interval, which covers the cycle before the pulse edge and the full pulse.

Top module: `trig_delay_gen`

## Requirements
- R1: The measured tap count is the index of the lowest zero bit of `therm_in`, where bit 0 is the earliest tap. The count is TAPS (50) when all bits are one. Ones above the first zero (bubbles) have no effect.
- R2: For a measured count m in 1..49, `tap_sel` equals 50−m. For m = 50, `tap_sel` is 0 and no extra cycle is added. `tap_sel` is always below 50.
- R3: For a measured count m = 0, `tap_sel` is 0 and the pulse comes exactly one cycle later than it would for a non-zero count.
- R4: `pulse_out` rises max(D,1)+x clock edges after the capture edge. D is `delay_cycles` and x is 1 when m = 0, otherwise 0.
- R5: `trig_in` passes through a two-flop synchronizer and a rising-edge detector. Capture happens on the third clock edge after `trig_in` rises. `busy` is high after that edge.
- R6: A trigger is ignored while `busy` is high, and also while `arm` is low. An ignored trigger starts no capture and no pulse, and does not shift the pulse already in progress.
- R7: `pulse_out` stays high for max(L,1) cycles, where L is `pulse_len`. `busy` falls on the same edge on which `pulse_out` falls.
- R8: `tap_sel` does not change while `busy` is high.
- R9: After reset, `pulse_out` and `busy` are low and `tap_sel` is 0.

Each state and transition named above (ST_IDLE, ST_COUNT, ST_PULSE, IDLE→COUNT, COUNT→PULSE, PULSE→IDLE) corresponds to the requirements R4 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous trigger, active on its rising edge |
| therm_in | input | 50 | Thermometer code from the input tapped delay line |
| delay_cycles | input | 16 | Whole-cycle delay D (0 is treated as 1) |
| pulse_len | input | 4 | Coarse pulse length L in cycles (0 is treated as 1) |
| arm | input | 1 | Allows a trigger to be accepted |
| pulse_out | output | 1 | Registered coarse output pulse |
| tap_sel | output | 6 | Tap of the output delay line that adds the complementary fraction |
| busy | output | 1 | High from capture until the pulse ends |

## Verification
On every cycle, the assertions check these rules: `tap_sel` stays stable while `busy` is high, its value stays in range, the pulse is only present while the block is busy, the pulse never starts on the capture edge, and `busy` ends together with the pulse. Some behaviours can only be shown by the bench's scenarios. These are the exact phase arithmetic for every measured count from 0 to 50 with and without bubbles, the extra cycle for a zero count, the latency from trigger to capture, the pulse timing and width for each delay and length, and the ignoring of triggers that arrive while busy or while disarmed.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } tdg_state_e;
endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tdg_therm_decode.sv
module tdg_therm_decode #(
    parameter int TAPS = 50,
    localparam int MW = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0] therm,
    output logic [MW-1:0]   count
);
    // Position of the lowest zero; bubbles above it are ignored.
    always_comb begin
        count = MW'(TAPS);
        for (int i = TAPS - 1; i >= 0; i--) begin
            if (!therm[i]) count = MW'(i);
        end
    end
endmodule

// File: rtl/tdg_tap_plan.sv
module tdg_tap_plan #(
    parameter int TAPS = 50,
    localparam int MW = $clog2(TAPS + 1),
    localparam int SW = $clog2(TAPS)
) (
    input  logic [MW-1:0] meas,
    output logic [SW-1:0] sel,
    output logic          extra
);
    always_comb begin
        extra = (meas == '0);
        if (meas == '0 || meas == MW'(TAPS)) sel = '0;
        else                                 sel = SW'(MW'(TAPS) - meas);
    end
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen #(
    parameter int TAPS   = 50,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 4,
    parameter int SYNC_N = 2,
    localparam int MW = $clog2(TAPS + 1),
    localparam int SW = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [TAPS-1:0]  therm_in,
    input  logic [CNT_W-1:0] delay_cycles,
    input  logic [LEN_W-1:0] pulse_len,
    input  logic             arm,
    output logic             pulse_out,
    output logic [SW-1:0]    tap_sel,
    output logic             busy
);
    import tdg_pkg::*;

    tdg_state_e state_q, state_d;
    logic           trig_s, trig_prev, trig_rise, start;
    logic [MW-1:0]  meas;
    logic [SW-1:0]  sel_w;
    logic           extra_w;
    logic [CNT_W:0] cnt_q, delay_eff;
    logic [LEN_W-1:0] len_q, len_eff;
    logic           cnt_done, len_done;

    tdg_sync #(.STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s)
    );

    tdg_therm_decode #(.TAPS(TAPS)) i_dec (
        .therm(therm_in), .count(meas)
    );

    tdg_tap_plan #(.TAPS(TAPS)) i_plan (
        .meas(meas), .sel(sel_w), .extra(extra_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_prev <= 1'b0;
        else        trig_prev <= trig_s;
    end

    assign trig_rise = trig_s & ~trig_prev;
    assign start     = (state_q == ST_IDLE) && trig_rise && arm;
    assign delay_eff = (delay_cycles == '0) ? (CNT_W+1)'(1) : {1'b0, delay_cycles};
    assign len_eff   = (pulse_len == '0) ? LEN_W'(1) : pulse_len;
    assign cnt_done  = (cnt_q <= (CNT_W+1)'(1));
    assign len_done  = (len_q <= LEN_W'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_COUNT;
            ST_COUNT: if (cnt_done) state_d = ST_PULSE;
            ST_PULSE: if (len_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            len_q     <= '0;
            tap_sel   <= '0;
            pulse_out <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q   <= delay_eff + (CNT_W+1)'(extra_w);
                        tap_sel <= sel_w;
                    end
                end
                ST_COUNT: begin
                    if (cnt_done) begin
                        pulse_out <= 1'b1;
                        len_q     <= len_eff;
                    end else begin
                        cnt_q <= cnt_q - (CNT_W+1)'(1);
                    end
                end
                ST_PULSE: begin
                    if (len_done) pulse_out <= 1'b0;
                    else          len_q     <= len_q - LEN_W'(1);
                end
                default: pulse_out <= 1'b0;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/tdg_checker.sv
module tdg_checker #(
    parameter int TAPS = 50,
    parameter int SW   = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          pulse_out,
    input logic [SW-1:0] tap_sel
);
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(tap_sel)); // R8
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) tap_sel < SW'(TAPS)); // R2
    AST_PULSE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) pulse_out |-> busy); // R7
    AST_PULSE_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(pulse_out) |-> !busy); // R7
    AST_NO_EARLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !pulse_out); // R4
endmodule

bind trig_delay_gen tdg_checker #(.TAPS(TAPS), .SW(SW)) i_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .pulse_out(pulse_out), .tap_sel(tap_sel)
);

// File: tb/test_trig_delay_gen.sv
`timescale 1ns/1ps
module test_trig_delay_gen;
    localparam int TAPS = 50;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trig_in = 1'b0;
    logic [TAPS-1:0] therm_in = '0;
    logic [15:0]     delay_cycles = 16'd1;
    logic [3:0]      pulse_len = 4'd0;
    logic            arm = 1'b1;
    logic            pulse_out, busy;
    logic [5:0]      tap_sel;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    trig_delay_gen i_trig_delay_gen (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .therm_in(therm_in),
        .delay_cycles(delay_cycles), .pulse_len(pulse_len), .arm(arm),
        .pulse_out(pulse_out), .tap_sel(tap_sel), .busy(busy)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full trigger run; m = measured count, bubble adds a one above the first zero
    task automatic run(input int m, input bit bubble, input int d, input int l,
                       input bit extra_trig);
        int t0, cb, cp, wdt, width, prev_sel, exp_sel, exp_dly, exp_w;
        therm_in = '0;
        for (int i = 0; i < TAPS; i++) if (i < m) therm_in[i] = 1'b1;
        if (bubble && m + 2 < TAPS) therm_in[m+2] = 1'b1;
        delay_cycles = 16'(d);
        pulse_len = 4'(l);
        exp_sel = (m == 0 || m == TAPS) ? 0 : TAPS - m;
        exp_dly = ((d == 0) ? 1 : d) + ((m == 0) ? 1 : 0);
        exp_w = (l == 0) ? 1 : l;
        @(posedge clk); #1 trig_in = 1'b1; t0 = cyc;
        wdt = 0;
        do begin @(negedge clk); wdt++; end while (!busy && wdt < 100);
        cb = cyc;
        check("R5 capture latency", cb - t0, 3);
        check("R1/R2/R3 tap_sel at capture", tap_sel, exp_sel);
        if (extra_trig) begin
            trig_in = 1'b0; @(negedge clk); trig_in = 1'b1;
        end
        prev_sel = tap_sel;
        wdt = 0;
        while (!pulse_out && wdt < 2000) begin prev_sel = tap_sel; @(negedge clk); wdt++; end
        cp = cyc;
        check("R4 R3 R6 pulse delay", cp - cb, exp_dly);
        check("R8 tap_sel before edge", prev_sel, exp_sel);
        width = 0;
        while (pulse_out && width < 100) begin
            check("R8 tap_sel during pulse", tap_sel, exp_sel);
            @(negedge clk); width++;
        end
        check("R7 pulse width", width, exp_w);
        check("R7 busy ends with pulse", busy, 0);
        trig_in = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (extra_trig) check("R6 no retrigger after busy", busy, 0);
        end
    endtask

    initial begin
        #(4.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #9;
        check("R9 reset pulse_out", pulse_out, 0);
        check("R9 reset busy", busy, 0);
        check("R9 reset tap_sel", tap_sel, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // sweep all measured counts, plain and with bubbles
        for (int m = 0; m <= TAPS; m++) begin
            int dl [4] = '{0, 1, 2, 5};
            run(m, 1'b0, dl[m % 4], m % 3, 1'b0);
            run(m, 1'b1, dl[(m + 1) % 4], (m + 1) % 3, 1'b0);
        end
        // zero count versus non-zero at same D
        run(0, 1'b0, 7, 2, 1'b0);
        run(25, 1'b0, 7, 2, 1'b0);
        // trigger during busy is ignored
        run(10, 1'b0, 9, 3, 1'b1);
        run(0, 1'b1, 4, 15, 1'b1);
        // disarmed trigger is ignored
        arm = 1'b0;
        @(negedge clk); trig_in = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check("R6 disarmed busy", busy, 0);
        end
        check("R6 disarmed pulse", pulse_out, 0);
        trig_in = 1'b0; arm = 1'b1;
        repeat (4) @(negedge clk);
        run(49, 1'b0, 3, 1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule